// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block sits beside a serial audio receiver and works out, with no configuration at all, how the incoming clocks relate to the audio frame. Every input is sampled by a free-running reference clock whose frequency is a parameter. The block counts master-clock and bit-clock rising edges between successive frame-sync rising edges. It also counts reference cycles per frame, which gives the sample rate and, through it, the absolute clock frequencies.

From these measurements it picks the timing source. When a master clock is present, the block checks its ratio against a restricted legal set and reports a divider that brings it down to a uniform internal rate. When the master clock is missing, the block falls back to deriving timing from the bit clock, which must then be fast enough. Downstream logic reads a ratio code, a divider, the chosen source, and valid/error flags. Results are published only after two frames agree, so a clock switch never shows a half-formed result.

Top module: `audio_clk_ratio_detect`

## Requirements
- R1: While reset is held and right after it, `ratio_valid`, `ratio_error`, `pll_mode`, `ratio_code` and `clk_div` are all zero.
- R2: A frame measurement is the number of master-clock rises, bit-clock rises and reference cycles between two frame-sync rises. The first frame-sync rise after reset only starts counting. Outputs change on the third reference edge after the edge at which the synchroniser captures the frame-sync rise, and only when that measurement's master count, bit count and master-absent flag equal those of the previous measurement.
- R3: With the master clock present, a master ratio that is a power of two of at least 128, and whose resulting frequency (ratio × reference frequency / reference cycles per frame) is at most 50 MHz, gives `ratio_valid`=1, `pll_mode`=0, `ratio_code`=log2(ratio) and `clk_div`=ratio/128.
- R4: A master ratio of 64 is accepted only when the reference cycles per frame lie within ±1/16 of the count expected at 384 kHz. It then gives `ratio_code`=6 and `clk_div`=1. At any other rate it is an error.
- R5: A master ratio that is not a power of two, that is below 64, or whose frequency exceeds 50 MHz is an error.
- R6: A bit-clock count other than 32, 48 or 64 per frame is an error in either mode.
- R7: The master clock counts as absent for a frame when, at some point in that frame, no master-clock rise has been seen for 64 reference cycles. An absent master clock selects `pll_mode`=1.
- R8: With `pll_mode`=1, a 32x or 64x bit clock reports `ratio_code`=7 (128x internal), a 48x bit clock reports `ratio_code`=0 (192x internal), and `clk_div` is 1.
- R9: With `pll_mode`=1, a bit-clock frequency below 1 MHz is an error and never a valid result.
- R10: A measurement that differs from the previous one clears `ratio_valid` and `ratio_error` at once. `pll_mode`, `ratio_code` and `clk_div` keep their values until two measurements agree again.
- R11: When agreed measurements are in error, `ratio_error`=1, `ratio_valid`=0, and `ratio_code` and `clk_div` read zero. `ratio_valid` and `ratio_error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock of frequency REF_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_in | input | 1 | Master clock, asynchronous, may be absent |
| bclk_in | input | 1 | Bit clock, asynchronous |
| lrck_in | input | 1 | Frame sync (left/right clock), asynchronous |
| ratio_valid | output | 1 | Agreed, legal ratio on the outputs |
| ratio_error | output | 1 | Agreed measurements form an illegal clock combination |
| pll_mode | output | 1 | 0: master-clock timing, 1: bit-clock-derived timing |
| ratio_code | output | 4 | log2 of the master ratio, 7 for 128x derived, 0 for 192x derived |
| clk_div | output | 10 | Divider to the uniform internal rate |

## Verification
The assertions assume that all three audio clocks are slower than half the reference clock, so every rise reaches the edge detectors as a separate pulse. They also assume the clocks' edges are stable at the reference edge that samples them. The stimulus derives every audio clock from counters of reference cycles: each high or low phase lasts at least one full reference period, and each clock changes only between reference edges. Scenario changes happen exactly at a frame-sync rise, so the mixed frames around a switch are well defined and the bench model can predict them too.

// File: rtl/acr_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the audio clock ratio detector.
// Assumes counts per frame fit in ACR_CNT_W bits; larger counts saturate.
package acr_pkg;
    localparam int ACR_CNT_W  = 16;
    localparam int ACR_CODE_W = $clog2(ACR_CNT_W);
    localparam int ACR_DIV_W  = ACR_CNT_W - 6;

    typedef enum logic {
        SRC_MCLK = 1'b0,
        SRC_BCLK = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic [ACR_CNT_W-1:0] mclk_cnt;
        logic [ACR_CNT_W-1:0] bclk_cnt;
        logic [ACR_CNT_W-1:0] ref_cnt;
        logic                 mclk_absent;
    } frame_meas_t;

    typedef struct packed {
        logic                  err;
        clk_src_e              src;
        logic [ACR_CODE_W-1:0] code;
        logic [ACR_DIV_W-1:0]  div;
    } ratio_res_t;
endpackage

// File: rtl/acr_edge_sync.sv
`timescale 1ns/1ps
// Brings one asynchronous audio clock into the reference domain and flags its rising edges.
// Assumes the input is slower than half the reference clock.
module acr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] pipe;

    // Shift the input through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/acr_frame_meter.sv
`timescale 1ns/1ps
// Counts master-clock rises, bit-clock rises and reference cycles per frame,
// and notes whether the master clock went quiet for GAP_LIMIT reference cycles.
// The first frame-sync rise after reset only arms the counters.
module acr_frame_meter
    import acr_pkg::*;
#(
    parameter int GAP_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mclk_rise,
    input  logic        bclk_rise,
    input  logic        lrck_rise,
    output frame_meas_t meas,
    output logic        meas_new
);
    localparam int GAP_W = $clog2(GAP_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_LIMIT);

    logic [ACR_CNT_W-1:0] mcnt, bcnt, rcnt;
    logic [GAP_W-1:0]     gap;
    logic                 gap_full, absent_seen, primed;

    function automatic logic [ACR_CNT_W-1:0] sat_add(input logic [ACR_CNT_W-1:0] a, input logic inc);
        logic [ACR_CNT_W:0] s;
        s = {1'b0, a} + {{ACR_CNT_W{1'b0}}, inc};
        return s[ACR_CNT_W] ? '1 : s[ACR_CNT_W-1:0];
    endfunction

    assign gap_full = (gap == GAP_MAX);

    // Track reference cycles since the last master-clock rise, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)         gap <= '0;
        else if (mclk_rise) gap <= '0;
        else if (!gap_full) gap <= gap + 1'b1;
    end

    // Accumulate the per-frame counts and restart them at every frame-sync rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0; bcnt <= '0; rcnt <= '0; absent_seen <= 1'b0;
        end else if (lrck_rise) begin
            mcnt <= '0; bcnt <= '0; rcnt <= '0; absent_seen <= 1'b0;
        end else begin
            mcnt        <= sat_add(mcnt, mclk_rise);
            bcnt        <= sat_add(bcnt, bclk_rise);
            rcnt        <= sat_add(rcnt, 1'b1);
            absent_seen <= absent_seen | gap_full;
        end
    end

    // Publish a completed frame once the counters have been armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas <= '0; meas_new <= 1'b0; primed <= 1'b0;
        end else begin
            meas_new <= 1'b0;
            if (lrck_rise) begin
                primed <= 1'b1;
                if (primed) begin
                    meas.mclk_cnt    <= sat_add(mcnt, mclk_rise);
                    meas.bclk_cnt    <= sat_add(bcnt, bclk_rise);
                    meas.ref_cnt     <= sat_add(rcnt, 1'b1);
                    meas.mclk_absent <= absent_seen | gap_full;
                    meas_new         <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/acr_classifier.sv
`timescale 1ns/1ps
// Turns one frame measurement into a timing source, ratio code, divider and error bit.
// Purely combinational; assumes REF_HZ is the true reference frequency.
module acr_classifier
    import acr_pkg::*;
#(
    parameter int REF_HZ      = 122_880_000,
    parameter int MCLK_MAX_HZ = 50_000_000,
    parameter int BCLK_MIN_HZ = 1_000_000,
    parameter int HI_RATE_HZ  = 384_000
) (
    input  frame_meas_t meas,
    output ratio_res_t  res
);
    localparam int HI_FRAME = REF_HZ / HI_RATE_HZ;
    localparam int HI_TOL   = HI_FRAME / 16;
    localparam logic [ACR_CNT_W-1:0] HI_LO = ACR_CNT_W'(HI_FRAME - HI_TOL);
    localparam logic [ACR_CNT_W-1:0] HI_HI = ACR_CNT_W'(HI_FRAME + HI_TOL);
    localparam logic [ACR_CODE_W-1:0] CODE_128 = ACR_CODE_W'(7);
    localparam logic [ACR_CODE_W-1:0] CODE_192 = '0;

    logic [63:0] mclk_hz_scaled, mclk_lim_scaled, bclk_hz_scaled, bclk_lim_scaled;
    logic        bclk_ok, is_pow2, hi_rate, mclk_ok, bclk_fast;
    logic [ACR_CODE_W-1:0] log2_m;

    assign mclk_hz_scaled  = 64'(meas.mclk_cnt) * 64'(REF_HZ);
    assign mclk_lim_scaled = 64'(MCLK_MAX_HZ) * 64'(meas.ref_cnt);
    assign bclk_hz_scaled  = 64'(meas.bclk_cnt) * 64'(REF_HZ);
    assign bclk_lim_scaled = 64'(BCLK_MIN_HZ) * 64'(meas.ref_cnt);

    assign bclk_ok   = (meas.bclk_cnt == 16'd32) || (meas.bclk_cnt == 16'd48) || (meas.bclk_cnt == 16'd64);
    assign is_pow2   = (meas.mclk_cnt != '0) && ((meas.mclk_cnt & (meas.mclk_cnt - 1'b1)) == '0);
    assign hi_rate   = (meas.ref_cnt >= HI_LO) && (meas.ref_cnt <= HI_HI);
    assign bclk_fast = (bclk_hz_scaled >= bclk_lim_scaled);
    assign mclk_ok   = is_pow2 && (mclk_hz_scaled <= mclk_lim_scaled) &&
                       ((meas.mclk_cnt >= 16'd128) || ((meas.mclk_cnt == 16'd64) && hi_rate));

    // Position of the highest set bit of the master count.
    always_comb begin
        log2_m = '0;
        for (int i = 0; i < ACR_CNT_W; i++) begin
            if (meas.mclk_cnt[i]) log2_m = ACR_CODE_W'(i);
        end
    end

    // Pick the source and its code and divider; flag illegal combinations.
    always_comb begin
        if (meas.mclk_absent) begin
            res.src  = SRC_BCLK;
            res.code = (meas.bclk_cnt == 16'd48) ? CODE_192 : CODE_128;
            res.div  = ACR_DIV_W'(1);
            res.err  = !bclk_ok || !bclk_fast;
        end else begin
            res.src  = SRC_MCLK;
            res.code = log2_m;
            res.div  = (meas.mclk_cnt == 16'd64) ? ACR_DIV_W'(1) : ACR_DIV_W'(meas.mclk_cnt >> 7);
            res.err  = !bclk_ok || !mclk_ok;
        end
    end
endmodule

// File: rtl/audio_clk_ratio_detect.sv
`timescale 1ns/1ps
// Audio clock ratio detector top: synchronises the three audio clocks, measures
// each frame, classifies it, and publishes a result once two frames agree.
// Assumes every audio clock runs below half the reference frequency.
module audio_clk_ratio_detect
    import acr_pkg::*;
#(
    parameter int REF_HZ       = 122_880_000,
    parameter int MCLK_MAX_HZ  = 50_000_000,
    parameter int BCLK_MIN_HZ  = 1_000_000,
    parameter int HI_RATE_HZ   = 384_000,
    parameter int MCLK_TIMEOUT = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  clk_ref,
    input  logic                  rst_n,
    input  logic                  mclk_in,
    input  logic                  bclk_in,
    input  logic                  lrck_in,
    output logic                  ratio_valid,
    output logic                  ratio_error,
    output logic                  pll_mode,
    output logic [ACR_CODE_W-1:0] ratio_code,
    output logic [ACR_DIV_W-1:0]  clk_div
);
    localparam int N_CLK = 3;

    logic [N_CLK-1:0] raw_clk, rise;
    frame_meas_t      meas, prev_meas;
    logic             meas_new, have_prev, same;
    ratio_res_t       res;

    assign raw_clk = {lrck_in, bclk_in, mclk_in};

    for (genvar g = 0; g < N_CLK; g++) begin : g_sync
        acr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk_ref),
            .rst_n(rst_n),
            .din  (raw_clk[g]),
            .rise (rise[g])
        );
    end

    acr_frame_meter #(.GAP_LIMIT(MCLK_TIMEOUT)) u_meter (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .mclk_rise(rise[0]),
        .bclk_rise(rise[1]),
        .lrck_rise(rise[2]),
        .meas     (meas),
        .meas_new (meas_new)
    );

    acr_classifier #(
        .REF_HZ     (REF_HZ),
        .MCLK_MAX_HZ(MCLK_MAX_HZ),
        .BCLK_MIN_HZ(BCLK_MIN_HZ),
        .HI_RATE_HZ (HI_RATE_HZ)
    ) u_class (
        .meas(meas),
        .res (res)
    );

    assign same = have_prev &&
                  (meas.mclk_cnt == prev_meas.mclk_cnt) &&
                  (meas.bclk_cnt == prev_meas.bclk_cnt) &&
                  (meas.mclk_absent == prev_meas.mclk_absent);

    // Remember the previous frame for the two-in-a-row agreement rule.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            prev_meas <= '0; have_prev <= 1'b0;
        end else if (meas_new) begin
            prev_meas <= meas; have_prev <= 1'b1;
        end
    end

    // Publish agreed results; drop the flags on any disagreement.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            ratio_valid <= 1'b0; ratio_error <= 1'b0; pll_mode <= 1'b0;
            ratio_code  <= '0;   clk_div     <= '0;
        end else if (meas_new) begin
            if (same) begin
                ratio_valid <= !res.err;
                ratio_error <= res.err;
                pll_mode    <= (res.src == SRC_BCLK);
                ratio_code  <= res.err ? '0 : res.code;
                clk_div     <= res.err ? '0 : res.div;
            end else begin
                ratio_valid <= 1'b0;
                ratio_error <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/acr_checker.sv
`timescale 1ns/1ps
// Property checker for the audio clock ratio detector, attached with bind.
// Assumes the reset and clock of the top module.
module acr_checker
    import acr_pkg::*;
(
    input logic                  clk_ref,
    input logic                  rst_n,
    input logic                  ratio_valid,
    input logic                  ratio_error,
    input logic                  pll_mode,
    input logic [ACR_CODE_W-1:0] ratio_code,
    input logic [ACR_DIV_W-1:0]  clk_div,
    input logic                  meas_new
);
    assert_flags_exclusive_R11: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(ratio_valid && ratio_error));

    assert_error_zeroed_R11: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ratio_error |-> (ratio_code == '0) && (clk_div == '0));

    assert_hold_between_frames_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !meas_new |=> $stable({ratio_valid, ratio_error, pll_mode, ratio_code, clk_div}));

    assert_mclk_code_floor_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ratio_valid && !pll_mode) |-> (ratio_code >= ACR_CODE_W'(6)) && (clk_div != '0));

    assert_x64_div_one_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ratio_valid && !pll_mode && ratio_code == ACR_CODE_W'(6)) |-> (clk_div == ACR_DIV_W'(1)));

    assert_derived_code_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ratio_valid && pll_mode) |-> (clk_div == ACR_DIV_W'(1)) &&
                                      ((ratio_code == ACR_CODE_W'(7)) || (ratio_code == '0)));
endmodule

bind audio_clk_ratio_detect acr_checker u_acr_checker (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .ratio_valid(ratio_valid),
    .ratio_error(ratio_error),
    .pll_mode   (pll_mode),
    .ratio_code (ratio_code),
    .clk_div    (clk_div),
    .meas_new   (meas_new)
);

// File: tb/tb_audio_clk_ratio_detect.sv
`timescale 1ns/1ps
// Bench: audio clocks built from reference-cycle counters, a behavioural frame
// model, and a four-edge delay line compared against the outputs on every clock.
module tb_audio_clk_ratio_detect;
    localparam int  REF_HZ  = 122_880_000;
    localparam int  MMAX_HZ = 50_000_000;
    localparam int  BMIN_HZ = 1_000_000;
    localparam int  HI_HZ   = 384_000;
    localparam int  TMO     = 64;

    typedef struct packed {
        logic       v;
        logic       e;
        logic       m;
        logic [3:0] c;
        logic [9:0] d;
    } out_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0, bclk = 1'b0, lrck = 1'b0;
    logic       ratio_valid, ratio_error, pll_mode;
    logic [3:0] ratio_code;
    logic [9:0] clk_div;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    audio_clk_ratio_detect dut (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .mclk_in    (mclk),
        .bclk_in    (bclk),
        .lrck_in    (lrck),
        .ratio_valid(ratio_valid),
        .ratio_error(ratio_error),
        .pll_mode   (pll_mode),
        .ratio_code (ratio_code),
        .clk_div    (clk_div)
    );

    // Model state
    out_t  pipe [4];
    out_t  mdl;
    logic  pm = 1'b0, pb = 1'b0, pl = 1'b0;
    int    gap = 0, fm = 0, fb = 0, fr = 0;
    bit    fa = 1'b0, primed = 1'b0, have_prev = 1'b0, prev_ab = 1'b0;
    int    prev_mc = 0, prev_bc = 0;
    string tag_s = "R2";

    function automatic out_t dut_out();
        out_t o;
        o.v = ratio_valid; o.e = ratio_error; o.m = pll_mode; o.c = ratio_code; o.d = clk_div;
        return o;
    endfunction

    task automatic check(string req, out_t exp);
        out_t got;
        got = dut_out();
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got v=%0b e=%0b pll=%0b code=%0d div=%0d, expected v=%0b e=%0b pll=%0b code=%0d div=%0d",
                     req, got.v, got.e, got.m, got.c, got.d, exp.v, exp.e, exp.m, exp.c, exp.d);
        end
    endtask

    // Classification from the requirements (R3..R9, R11)
    task automatic classify(input int mc, input int bc, input int rc, input bit ab,
                            output bit err, output bit md, output int code, output int div);
        bit bok, pow2, hi, legal;
        int hf, tol;
        bok = (bc == 32) || (bc == 48) || (bc == 64);
        if (ab) begin
            md   = 1'b1;
            code = (bc == 48) ? 0 : 7;
            div  = 1;
            err  = !bok || (longint'(bc) * REF_HZ < longint'(BMIN_HZ) * rc);
        end else begin
            md   = 1'b0;
            pow2 = 1'b0;
            code = 0;
            for (int k = 0; k < 16; k++) if (mc == (1 << k)) begin pow2 = 1'b1; code = k; end
            hf    = REF_HZ / HI_HZ;
            tol   = hf / 16;
            hi    = (rc >= hf - tol) && (rc <= hf + tol);
            legal = pow2 && ((mc >= 128) || (mc == 64 && hi)) &&
                    (longint'(mc) * REF_HZ <= longint'(MMAX_HZ) * rc);
            err   = !legal || !bok;
            div   = (mc == 64) ? 1 : mc / 128;
        end
    endtask

    task automatic process_frame(int mc, int bc, int rc, bit ab);
        bit err, md;
        int code, div;
        classify(mc, bc, rc, ab, err, md, code, div);
        if (have_prev && mc == prev_mc && bc == prev_bc && ab == prev_ab) begin
            mdl.v = !err;
            mdl.e = err;
            mdl.m = md;
            mdl.c = err ? 4'd0 : 4'(code);
            mdl.d = err ? 10'd0 : 10'(div);
        end else begin
            mdl.v = 1'b0;
            mdl.e = 1'b0;
        end
        prev_mc = mc; prev_bc = bc; prev_ab = ab; have_prev = 1'b1;
    endtask

    task automatic model_tick(logic m, logic b, logic l);
        bit mr, br, lr;
        mr = m && !pm; br = b && !pb; lr = l && !pl;
        if (gap >= TMO) fa = 1'b1;
        fm += int'(mr); fb += int'(br); fr += 1;
        if (lr) begin
            if (primed) process_frame(fm, fb, fr, fa);
            primed = 1'b1;
            fm = 0; fb = 0; fr = 0; fa = 1'b0;
        end
        gap = mr ? 0 : ((gap < TMO) ? gap + 1 : TMO);
        pm = m; pb = b; pl = l;
    endtask

    // One reference tick: compare, drive, model, shift the delay line.
    task automatic step(int t, int p, int q, int f);
        logic m, b, l;
        @(negedge clk);
        check(tag_s, pipe[3]);
        m = (p > 0) ? ((t % p) < (p + 1) / 2) : 1'b0;
        b = (t % q) < (q + 1) / 2;
        l = (t % f) < f / 2;
        mclk = m; bclk = b; lrck = l;
        model_tick(m, b, l);
        pipe[3] = pipe[2]; pipe[2] = pipe[1]; pipe[1] = pipe[0]; pipe[0] = mdl;
    endtask

    // Run one clock set-up; p = 0 means no master clock. Final outputs checked against fixed values.
    task automatic run_scn(string req, int p, int q, int f, int frames, out_t fin);
        for (int t = 0; t < f * frames; t++) begin
            tag_s = (t < 2 * f) ? {req, "/R2/R10"} : req;
            step(t, p, q, f);
        end
        @(negedge clk);
        check({req, " final"}, fin);
        check({req, " final model"}, pipe[3]);
        // hold the last tick's inputs for the extra edge: model one repeated tick
        model_tick(mclk, bclk, lrck);
        pipe[3] = pipe[2]; pipe[2] = pipe[1]; pipe[1] = pipe[0]; pipe[0] = mdl;
    endtask

    function automatic out_t mk(logic v, logic e, logic m, int c, int d);
        out_t o;
        o.v = v; o.e = e; o.m = m; o.c = 4'(c); o.d = 10'(d);
        return o;
    endfunction

    initial begin
        mdl = '0;
        for (int i = 0; i < 4; i++) pipe[i] = '0;
        repeat (5) @(negedge clk);
        check("R1 reset", mk(0, 0, 0, 0, 0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", mk(0, 0, 0, 0, 0));
        model_tick(1'b0, 1'b0, 1'b0);
        pipe[3] = pipe[2]; pipe[2] = pipe[1]; pipe[1] = pipe[0]; pipe[0] = mdl;

        run_scn("R3 256x",           4,  16, 1024, 5, mk(1, 0, 0, 8, 2));
        run_scn("R3 512x",           3,  24, 1536, 5, mk(1, 0, 0, 9, 4));
        run_scn("R4 64x at 384k",    5,   5,  320, 5, mk(1, 0, 0, 6, 1));
        run_scn("R4/R11 64x slow",   8,   8,  512, 5, mk(0, 1, 0, 0, 0));
        run_scn("R5/R11 over 50MHz", 2,   8,  256, 5, mk(0, 1, 0, 0, 0));
        run_scn("R5 192x master",    4,  16,  768, 5, mk(0, 1, 0, 0, 0));
        run_scn("R6 40x bit clock",  5,   8,  320, 5, mk(0, 1, 0, 0, 0));
        run_scn("R7/R8 48x derived", 0,   8,  384, 5, mk(1, 0, 1, 0, 1));
        run_scn("R8 32x derived",    0,   4,  128, 6, mk(1, 0, 1, 7, 1));
        run_scn("R9 slow bit clock", 0, 128, 4096, 4, mk(0, 1, 1, 0, 0));
        run_scn("R10 master returns",4,  16, 1024, 4, mk(1, 0, 0, 8, 2));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion before 190000 cycles");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule